// File: doc/BRIEF.md
# Always-on wakeup interrupt aggregator with NMI latch

This block collects interrupt sources that must stay live while the rest of the chip sleeps and turns them into one wakeup request. Three kinds of source feed a 32-bit top-level vector. The first is an external non-maskable pad. The second is a set of direct interrupt lines. The third is a wide bus of multiplexed sources, folded eight at a time into group bits. Software controls the block over a simple 32-bit register bus. It programs per-bit enables, per-source mux enables and the pad sense mode, reads the gated pending vector, and clears the pad latch.

The pad is resynchronised by two flops and compared with its value one cycle earlier. One of four sense modes then sets a latch. The latch drives `nmi_irq_o` as an active-high level in every mode. It stays set until software writes 1 to bit 0 of the pending word. Direct and group bits are not stored: they read as the live input ANDed with the relevant enables. The wakeup request is the OR of every enabled pending bit.

Top module: `wake_intc`

## Requirements
- R1: After reset, all top-level enables and mux enables are 0, the pad sense mode is 0 (level-low), and `nmi_irq_o` and `wake_o` are 0. The pad synchroniser resets to the pad-high value.
- R2: The sense mode is written to bits [1:0] at offset 0x0C. Code 0 sets the latch while the synchronised pad is low, code 2 while it is high, code 1 on a high-to-low change and code 3 on a low-to-high change.
- R3: Writing a word with bit 0 set to offset 0x10 clears the latch on that edge. In a level mode, a pad that is still active sets the latch again on the following edge. In an edge mode the latch stays clear until a new edge arrives. Writing 0 to bit 0 leaves the latch unchanged.
- R4: `nmi_irq_o` equals the latch and is active-high in all four modes. It does not depend on the enable of bit 0.
- R5: Pending bit 0, read at offset 0x10, is the latch ANDed with enable bit 0. Enables are written and read at offset 0x40.
- R6: Pending bits 1 to 15 read as direct line i-1 ANDed with enable bit i.
- R7: Pending bit 19+k is the OR over sources 8k to 8k+7 of (source AND its mux-enable bit), ANDed with enable bit 19+k. Mux enable for source j sits at offset 0xC0+4*(j/32), bit j%32.
- R8: `wake_o` is high exactly when any pending bit is high.
- R9: Enable bits 16 to 18 and mux-enable bits for sources above 103 are read-only 0. Unmapped offsets, such as 0x14 and 0x80, read 0.
- R10: A pad change reaches `nmi_irq_o` on the third rising clock edge after it, in both edge and level modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| nmi_pad_i | input | 1 | Asynchronous external NMI pad |
| direct_irq_i | input | 15 | Direct lines feeding pending bits 1..15 |
| mux_src_i | input | 104 | Multiplexed sources, 8 per group bit |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| nmi_irq_o | output | 1 | Latched NMI, active-high level |
| wake_o | output | 1 | OR of all enabled pending bits |

## Verification
The NMI path is tried in all four sense modes. Each mode gets a pad held steady, a pad toggled in the wrong direction and a pad toggled in the right direction. Together these separate level from edge sensing and rising from falling. Clearing the latch with the pad still active separates re-arming in level mode from staying clear in edge mode. The group path drives a source whose mux enable is off and another whose top-level enable is off, which shows that both gates apply. Direct lines with mixed enables show that the gating works per bit, and an all-ones enable write exposes the read-only holes.

// File: rtl/wake_intc_pkg.sv
package wake_intc_pkg;
  typedef enum logic [1:0] {
    SENSE_LVL_LO = 2'd0,
    SENSE_FALL   = 2'd1,
    SENSE_LVL_HI = 2'd2,
    SENSE_RISE   = 2'd3
  } sense_e;

  localparam logic [7:0] OFS_NMI_CTRL = 8'h0C;
  localparam logic [7:0] OFS_PEND     = 8'h10;
  localparam logic [7:0] OFS_EN       = 8'h40;
  localparam logic [7:0] OFS_MUXEN    = 8'hC0;
endpackage

// File: rtl/wake_intc_nmi.sv
module wake_intc_nmi
  import wake_intc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   pad_i,
  input  sense_e mode_i,
  input  logic   clr_i,
  output logic   irq_o
);
  logic s1_q, s2_q, prev_q, hit, latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= pad_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  always_comb begin
    unique case (mode_i)
      SENSE_LVL_LO: hit = !s2_q;
      SENSE_FALL:   hit = prev_q && !s2_q;
      SENSE_LVL_HI: hit = s2_q;
      SENSE_RISE:   hit = s2_q && !prev_q;
      default:      hit = 1'b0;
    endcase
  end

  // clear wins in its cycle; a held level re-sets on the next edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    latch_q <= 1'b0;
    else if (clr_i) latch_q <= 1'b0;
    else if (hit)   latch_q <= 1'b1;
  end

  assign irq_o = latch_q;

  // R3
  nmi_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !irq_o);

  // R2
  nmi_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SENSE_RISE && s2_q && !prev_q && !clr_i) |=> irq_o);
endmodule

// File: rtl/wake_intc_grp.sv
module wake_intc_grp #(
  parameter int W = 8
) (
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] en_i,
  output logic         hit_o
);
  assign hit_o = |(src_i & en_i);
endmodule

// File: rtl/wake_intc.sv
module wake_intc
  import wake_intc_pkg::*;
#(
  parameter int N_DIRECT = 15,
  parameter int GRP_BASE = 19,
  parameter int N_GRP    = 13,
  parameter int GRP_W    = 8,
  parameter int DW       = 32,
  parameter int AW       = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   nmi_pad_i,
  input  logic [N_DIRECT-1:0]    direct_irq_i,
  input  logic [N_GRP*GRP_W-1:0] mux_src_i,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [DW-1:0]          rdata_o,
  output logic                   nmi_irq_o,
  output logic                   wake_o
);
  localparam int MUX_W     = N_GRP * GRP_W;
  localparam int MUX_WORDS = (MUX_W + DW - 1) / DW;
  localparam int MUX_PAD   = MUX_WORDS * DW;

  function automatic logic [DW-1:0] en_mask_f();
    logic [DW-1:0] m;
    for (int i = 0; i < DW; i++)
      m[i] = (i <= N_DIRECT) || (i >= GRP_BASE && i < GRP_BASE + N_GRP);
    return m;
  endfunction

  function automatic logic [MUX_PAD-1:0] mux_mask_f();
    logic [MUX_PAD-1:0] m;
    for (int i = 0; i < MUX_PAD; i++) m[i] = (i < MUX_W);
    return m;
  endfunction

  localparam logic [DW-1:0]      EN_MASK  = en_mask_f();
  localparam logic [MUX_PAD-1:0] MUX_MASK = mux_mask_f();

  sense_e             ctrl_q;
  logic [DW-1:0]      en_q;
  logic [MUX_PAD-1:0] muxen_q;
  logic [DW-1:0]      pend;
  logic [N_GRP-1:0]   grp_hit;
  logic               wr, nmi_clr;

  assign wr      = req_i && we_i;
  assign nmi_clr = wr && (addr_i == AW'(OFS_PEND)) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= SENSE_LVL_LO;
      en_q    <= '0;
      muxen_q <= '0;
    end else if (wr) begin
      if (addr_i == AW'(OFS_NMI_CTRL)) ctrl_q <= sense_e'(wdata_i[1:0]);
      if (addr_i == AW'(OFS_EN))       en_q   <= wdata_i & EN_MASK;
      for (int w = 0; w < MUX_WORDS; w++)
        if (addr_i == AW'(OFS_MUXEN) + AW'(4 * w))
          muxen_q[w*DW +: DW] <= wdata_i & MUX_MASK[w*DW +: DW];
    end
  end

  wake_intc_nmi u_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pad_i  (nmi_pad_i),
    .mode_i (ctrl_q),
    .clr_i  (nmi_clr),
    .irq_o  (nmi_irq_o)
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    wake_intc_grp #(.W(GRP_W)) u_grp (
      .src_i (mux_src_i[g*GRP_W +: GRP_W]),
      .en_i  (muxen_q[g*GRP_W +: GRP_W]),
      .hit_o (grp_hit[g])
    );
  end

  always_comb begin
    pend    = '0;
    pend[0] = nmi_irq_o && en_q[0];
    for (int i = 0; i < N_DIRECT; i++)
      pend[1+i] = direct_irq_i[i] && en_q[1+i];
    for (int k = 0; k < N_GRP; k++)
      pend[GRP_BASE+k] = grp_hit[k] && en_q[GRP_BASE+k];
  end

  assign wake_o = |pend;

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(OFS_NMI_CTRL)) rdata_o[1:0] = ctrl_q;
    else if (addr_i == AW'(OFS_PEND)) rdata_o = pend;
    else if (addr_i == AW'(OFS_EN))   rdata_o = en_q;
    else
      for (int w = 0; w < MUX_WORDS; w++)
        if (addr_i == AW'(OFS_MUXEN) + AW'(4 * w)) rdata_o = muxen_q[w*DW +: DW];
  end

  // R8
  wake_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (en_q != '0));

  // R3
  pend_zero_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == AW'(OFS_PEND) && !wdata_i[0] && nmi_irq_o) |=> nmi_irq_o);

  // R5
  nmi_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_irq_o && en_q[0] && addr_i == AW'(OFS_PEND)) |-> rdata_o[0]);

  // R9
  rsvd_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == AW'(OFS_EN)) |-> (rdata_o[GRP_BASE-1:N_DIRECT+1] == '0));
endmodule

// File: tb/wake_intc_tb_top.sv
module wake_intc_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         pad;
  logic [14:0]  direct;
  logic [103:0] msrc;
  logic         req, we;
  logic [7:0]   addr;
  logic [31:0]  wdata, rdata;
  logic         nmi, wake;

  always #10 clk = ~clk;

  wake_intc dut_i (
    .clk_i(clk), .rst_ni(rst_n), .nmi_pad_i(pad), .direct_irq_i(direct),
    .mux_src_i(msrc), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .nmi_irq_o(nmi), .wake_o(wake)
  );

  int          n_chk = 0, n_fail = 0;
  bit          done = 0;
  int          q_sel[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];
  event        smp_ev;

  // monitor: pops expected items and compares against the live outputs
  initial forever begin
    @(smp_ev);
    #2;
    while (q_sel.size() > 0) begin
      int          sel;
      logic [31:0] exp, act;
      string       tag;
      sel = q_sel.pop_front();
      exp = q_exp.pop_front();
      tag = q_tag.pop_front();
      act = (sel == 0) ? rdata : (sel == 1) ? {31'b0, nmi} : {31'b0, wake};
      n_chk++;
      if (act !== exp) begin
        n_fail++;
        $display("FAIL %s: sel=%0d actual=%h expected=%h", tag, sel, act, exp);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic push(input int sel, input logic [31:0] e, input string tag);
    q_sel.push_back(sel); q_exp.push_back(e); q_tag.push_back(tag);
    -> smp_ev;
    @(negedge clk);
  endtask

  task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    addr = a; req = 0; we = 0;
    push(0, e, tag);
  endtask

  task automatic chk_nmi(input logic e, input string tag);
    push(1, {31'b0, e}, tag);
  endtask

  task automatic chk_wake(input logic e, input string tag);
    push(2, {31'b0, e}, tag);
  endtask

  initial begin
    #4ms;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pad = 1; direct = '0; msrc = '0;
    req = 0; we = 0; addr = '0; wdata = '0;
    tick(2);
    // R1 reset values
    chk_rd(8'h40, 32'h0, "R1");
    chk_rd(8'h0C, 32'h0, "R1");
    chk_rd(8'hC0, 32'h0, "R1");
    chk_nmi(1'b0, "R1");
    chk_wake(1'b0, "R1");
    rst_n = 1;
    tick(4);
    chk_nmi(1'b0, "R1");

    // R6 direct lines, mixed enables
    wr(8'h40, 32'h0000_0022);
    direct = 15'h0014;               // pending bits 3 and 5 driven
    chk_rd(8'h10, 32'h0000_0020, "R6");
    chk_wake(1'b1, "R8");
    direct = '0;
    chk_rd(8'h10, 32'h0, "R6");
    chk_wake(1'b0, "R8");

    // R7 groups: src 8 -> bit 20, src 0 mux-gated, src 100 top-gated
    wr(8'h40, 32'h0018_0000);
    wr(8'hC0, 32'h0000_0100);
    wr(8'hCC, 32'h0000_0010);
    msrc = '0; msrc[8] = 1; msrc[0] = 1; msrc[100] = 1;
    chk_rd(8'h10, 32'h0010_0000, "R7");
    wr(8'h40, 32'h8018_0000);
    chk_rd(8'h10, 32'h8010_0000, "R7");
    chk_wake(1'b1, "R8");
    msrc = '0;
    chk_wake(1'b0, "R8");

    // R9 read-only holes and unmapped offsets
    wr(8'h40, 32'hFFFF_FFFF);
    chk_rd(8'h40, 32'hFFF8_FFFF, "R9");
    wr(8'hCC, 32'hFFFF_FFFF);
    chk_rd(8'hCC, 32'h0000_00FF, "R9");
    chk_rd(8'h14, 32'h0, "R9");
    chk_rd(8'h80, 32'h0, "R9");

    // R2/R3 level-high with pad held high
    wr(8'h0C, 32'h2);
    chk_rd(8'h0C, 32'h2, "R2");
    tick(1);
    chk_nmi(1'b1, "R2");
    chk_rd(8'h10, 32'h0000_0001, "R5");
    wr(8'h10, 32'h1);
    chk_nmi(1'b0, "R3");
    chk_nmi(1'b1, "R3");
    pad = 0;
    tick(4);
    wr(8'h10, 32'h1);
    tick(3);
    chk_nmi(1'b0, "R2");

    // level-low with pad low; writing 0 does not clear
    wr(8'h0C, 32'h0);
    tick(3);
    chk_nmi(1'b1, "R2");
    wr(8'h10, 32'h0);
    tick(1);
    chk_nmi(1'b1, "R3");
    pad = 1;
    tick(4);
    wr(8'h10, 32'h1);
    tick(2);
    chk_nmi(1'b0, "R3");

    // rising: held high and falling do not set; rising sets on edge 3
    wr(8'h0C, 32'h3);
    tick(3);
    chk_nmi(1'b0, "R2");
    pad = 0;
    tick(4);
    chk_nmi(1'b0, "R2");
    pad = 1;
    tick(2);
    chk_nmi(1'b0, "R10");
    chk_nmi(1'b1, "R10");
    wr(8'h10, 32'h1);
    tick(3);
    chk_nmi(1'b0, "R3");

    // falling
    wr(8'h0C, 32'h1);
    tick(3);
    chk_nmi(1'b0, "R2");
    pad = 0;
    tick(2);
    chk_nmi(1'b0, "R10");
    chk_nmi(1'b1, "R2");
    wr(8'h10, 32'h1);
    tick(3);
    chk_nmi(1'b0, "R3");

    // R4 output independent of enable bit 0
    wr(8'h40, 32'h0);
    wr(8'h0C, 32'h0);
    tick(2);
    chk_nmi(1'b1, "R4");
    chk_rd(8'h10, 32'h0, "R5");
    chk_wake(1'b0, "R8");

    tick(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule